// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast-Line Routing

This block collects level-sensitive interrupt requests from up to 128 sources and presents them to a processor on two lines: a normal interrupt line and a fast interrupt line. Each source has a mask bit, a software-raised request bit and an 8-bit level register. The level register holds a 7-bit priority and a routing bit that picks which of the two lines the source competes for. A separate arbiter serves each line. It chooses the most urgent eligible source, raises its line, and publishes the chosen source number in a status register.

A chosen source stays latched even if its request later drops or a more urgent one arrives. Software reads the status register, services the source, and then writes a re-arbitration command for that line. The line falls, stays low for two cycles, and the arbiter picks again. Masks and software requests are changed through write-one-to-set and write-one-to-clear registers, so no read-modify-write sequence is needed. Register access is a single-cycle write strobe with word addresses, and reads are combinational from the address.

Top module: `prio_intc`

## Requirements
- R1: Source n belongs to bank n>>5 at bit n&31. The registers of bank b sit at word address 0x10+8*b: +0 mask (read), +1 mask set, +2 mask clear, +3 raw pending (read), +4 software set, +5 software clear.
- R2: A write to mask set or mask clear changes only the mask bits written as 1. Bits written as 0 keep their value. The mask register reads back the current mask bits.
- R3: A source is pending when its hardware input is high or its software request bit is set. Software set raises the request bit and software clear removes it, only for bits written as 1.
- R4: The raw pending register of a bank shows the pending state of its 32 sources whether or not they are masked.
- R5: The level register of source n is at word address 0x100+n. Bits [8:2] hold the priority, and bit 0 routes the source to the fast line (1) or the normal line (0). All other bits read 0.
- R6: Only sources that are pending, unmasked and routed to a line compete for that line. The lower priority value wins, and ties go to the lower source number.
- R7: The normal status register (address 0x01) and the fast status register (address 0x02) report the held source number in bits [6:0], or 0x7F when nothing is held. Each output line is high exactly while its arbiter holds a selection.
- R8: A held selection does not change while no re-arbitration command arrives, whatever the sources do.
- R9: Writing address 0x00 with bit 0 set re-arbitrates the normal line, and with bit 1 set re-arbitrates the fast line. The line drops on the clock edge that takes the write and stays low for two cycles. It may rise again on the second edge after the write. The other line is not affected.
- R10: After reset every mask bit is 1, every software request and level register is 0, both lines are low and both status registers read 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | N_SRC | Level-sensitive hardware requests |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The bench builds the block with its default values: 128 sources in four banks and a 9-bit address. At this size a full sweep is cheap. Every level register is written and read back, and every source is raised alone by software so that both its bank/bit placement and its routing to the right line are checked. The bench also holds its own copy of the priorities and routes. From this copy it computes the expected winner for whole-array request patterns, for ties and for masked winners, and it checks the re-arbitration gap cycle by cycle.

// File: rtl/prio_intc_pkg.sv
// Shared constants and types of the interrupt controller.
// Assumes word addressing and a 32-bit register bus.
package prio_intc_pkg;
    localparam int DATA_W      = 32;
    localparam int BANK_W      = 32;
    localparam int ID_W        = 7;
    localparam int PRIO_W      = 7;
    localparam logic [ID_W-1:0] ID_NONE = '1;

    // word addresses of the register map
    localparam int ADR_CTRL     = 0;
    localparam int ADR_NSTAT    = 1;
    localparam int ADR_FSTAT    = 2;
    localparam int BANK_BASE    = 16;
    localparam int BANK_STRIDE  = 8;
    localparam int OFS_MASK     = 0;
    localparam int OFS_MSET     = 1;
    localparam int OFS_MCLR     = 2;
    localparam int OFS_RAW      = 3;
    localparam int OFS_SSET     = 4;
    localparam int OFS_SCLR     = 5;
    localparam int LEVEL_BASE   = 256;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              to_fast;
    } level_t;

    typedef enum logic [1:0] {
        ARB_OPEN = 2'd0,
        ARB_HELD = 2'd1,
        ARB_GAP  = 2'd2
    } arb_state_t;
endpackage

// File: rtl/prio_intc_regfile.sv
// Per-source configuration storage: masks, software requests, level registers.
// Decodes bank and level writes, and serves bank and level reads.
// Assumes N_SRC is a multiple of 32, at most 128, and ADDR_W is wide enough
// to reach LEVEL_BASE + N_SRC - 1.
module prio_intc_regfile
    import prio_intc_pkg::*;
#(
    parameter int N_SRC  = 128,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  pend_o,
    output level_t            lvl_o [N_SRC]
);
    localparam int NBANK = N_SRC / BANK_W;

    logic [N_SRC-1:0] swreq_q;

    // address of a register inside bank b
    function automatic logic [ADDR_W-1:0] bank_adr(input int b, input int ofs);
        return ADDR_W'(BANK_BASE + b * BANK_STRIDE + ofs);
    endfunction

    // address of the level register of source n
    function automatic logic [ADDR_W-1:0] level_adr(input int n);
        return ADDR_W'(LEVEL_BASE + n);
    endfunction

    assign pend_o = src_in | swreq_q;

    // mask and software-request bits, write-one-to-set / write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o  <= '1;
            swreq_q <= '0;
        end else if (bus_wen) begin
            for (int b = 0; b < NBANK; b++) begin
                if (bus_addr == bank_adr(b, OFS_MSET))
                    mask_o[b*BANK_W +: BANK_W] <= mask_o[b*BANK_W +: BANK_W] | bus_wdata;
                if (bus_addr == bank_adr(b, OFS_MCLR))
                    mask_o[b*BANK_W +: BANK_W] <= mask_o[b*BANK_W +: BANK_W] & ~bus_wdata;
                if (bus_addr == bank_adr(b, OFS_SSET))
                    swreq_q[b*BANK_W +: BANK_W] <= swreq_q[b*BANK_W +: BANK_W] | bus_wdata;
                if (bus_addr == bank_adr(b, OFS_SCLR))
                    swreq_q[b*BANK_W +: BANK_W] <= swreq_q[b*BANK_W +: BANK_W] & ~bus_wdata;
            end
        end
    end

    // level registers, one per source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < N_SRC; n++) lvl_o[n] <= '0;
        end else if (bus_wen) begin
            for (int n = 0; n < N_SRC; n++)
                if (bus_addr == level_adr(n))
                    lvl_o[n] <= level_t'({bus_wdata[PRIO_W+1:2], bus_wdata[0]});
        end
    end

    // read mux for bank and level registers
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == bank_adr(b, OFS_MASK)) rd_data = mask_o[b*BANK_W +: BANK_W];
            if (bus_addr == bank_adr(b, OFS_RAW))  rd_data = pend_o[b*BANK_W +: BANK_W];
        end
        for (int n = 0; n < N_SRC; n++)
            if (bus_addr == level_adr(n))
                rd_data = {{(DATA_W-PRIO_W-2){1'b0}}, lvl_o[n].prio, 1'b0, lvl_o[n].to_fast};
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank_chk
        AST_MSET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wen && bus_addr == bank_adr(gb, OFS_MSET)) |=>
            ((mask_o[gb*BANK_W +: BANK_W] & $past(bus_wdata)) == $past(bus_wdata))); // R2
        AST_MCLR_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wen && bus_addr == bank_adr(gb, OFS_MCLR)) |=>
            ((mask_o[gb*BANK_W +: BANK_W] & ~$past(bus_wdata)) ==
             ($past(mask_o[gb*BANK_W +: BANK_W]) & ~$past(bus_wdata)))); // R2
    end
endmodule

// File: rtl/prio_intc_arbiter.sv
// One line's arbiter: scans competing sources, latches the winner and holds it
// until a re-arbitration strobe, then waits one gap cycle before picking again.
// Assumes req_i is already pending-and-unmasked; the route is filtered here.
module prio_intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int N_SRC     = 128,
    parameter bit ROUTE_FST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  level_t           lvl_i [N_SRC],
    input  logic             rearm_i,
    output logic             valid_o,
    output logic [ID_W-1:0]  id_o
);
    arb_state_t        state_q;
    logic [N_SRC-1:0]  elig;
    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    // sources competing on this line
    always_comb begin
        for (int n = 0; n < N_SRC; n++)
            elig[n] = req_i[n] && (lvl_i[n].to_fast == ROUTE_FST);
    end

    // lowest priority value wins, strict compare keeps the lower number on ties
    always_comb begin
        found   = 1'b0;
        best_p  = '1;
        best_id = ID_NONE;
        for (int n = 0; n < N_SRC; n++) begin
            if (elig[n] && (!found || lvl_i[n].prio < best_p)) begin
                found   = 1'b1;
                best_p  = lvl_i[n].prio;
                best_id = ID_W'(n);
            end
        end
    end

    // hold / gap / open sequencing of the selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_OPEN;
            id_o    <= ID_NONE;
        end else if (rearm_i) begin
            state_q <= ARB_GAP;
            id_o    <= ID_NONE;
        end else begin
            unique case (state_q)
                ARB_OPEN: if (found) begin
                    state_q <= ARB_HELD;
                    id_o    <= best_id;
                end
                ARB_GAP:  state_q <= ARB_OPEN;
                default:  state_q <= ARB_HELD;
            endcase
        end
    end

    assign valid_o = (state_q == ARB_HELD);

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !rearm_i) |=> (valid_o && $stable(id_o))); // R8
    AST_REARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> (!valid_o && id_o == ID_NONE)); // R9
    AST_OPEN_PICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_OPEN && !rearm_i && (|elig)) |=> valid_o); // R6
    AST_IDLE_REPORTS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (id_o == ID_NONE)); // R7
endmodule

// File: rtl/prio_intc.sv
// Top of the interrupt controller: register file, one arbiter per output line,
// control decode and status read mux.
// Assumes a single-cycle write strobe and combinational reads.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_SRC  = 128,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [N_SRC-1:0] mask;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] live;
    level_t           lvl [N_SRC];
    logic [DATA_W-1:0] rf_rd;
    logic [1:0]       rearm;
    logic [1:0]       sel_vld;
    logic [ID_W-1:0]  sel_id [2];

    prio_intc_regfile #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_data   (rf_rd),
        .mask_o    (mask),
        .pend_o    (pend),
        .lvl_o     (lvl)
    );

    assign live = pend & ~mask;

    // re-arbitration strobes, bit 0 normal line, bit 1 fast line
    always_comb begin
        for (int r = 0; r < 2; r++)
            rearm[r] = bus_wen && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[r];
    end

    for (genvar gr = 0; gr < 2; gr++) begin : g_line
        prio_intc_arbiter #(.N_SRC(N_SRC), .ROUTE_FST(gr == 1)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (live),
            .lvl_i   (lvl),
            .rearm_i (rearm[gr]),
            .valid_o (sel_vld[gr]),
            .id_o    (sel_id[gr])
        );
    end

    assign irq_o = sel_vld[0];
    assign fiq_o = sel_vld[1];

    // status and configuration read mux
    always_comb begin
        if (bus_addr == ADDR_W'(ADR_NSTAT))
            bus_rdata = {{(DATA_W-ID_W){1'b0}}, sel_id[0]};
        else if (bus_addr == ADDR_W'(ADR_FSTAT))
            bus_rdata = {{(DATA_W-ID_W){1'b0}}, sel_id[1]};
        else if (bus_addr == ADDR_W'(ADR_CTRL))
            bus_rdata = '0;
        else
            bus_rdata = rf_rd;
    end

    AST_LINES_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o)); // R10
endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src_in = '0;
    logic         bus_wen = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_o, fiq_o;

    int checks = 0;
    int fails  = 0;
    int bp [128];
    bit br [128];
    logic [31:0] rv;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int adr, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = 9'(adr); bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input int adr, output logic [31:0] d);
        bus_addr = 9'(adr);
        #1;
        d = bus_rdata;
    endtask

    function automatic int badr(input int b, input int ofs);
        return 16 + 8 * b + ofs;
    endfunction

    task automatic set_level(input int n, input int p, input bit f);
        bp[n] = p; br[n] = f;
        wr(256 + n, 32'hFFFF_FE02 | (32'(p) << 2) | 32'(f));
    endtask

    // expected winner for a request vector on one line, 127 coded as none
    function automatic logic [31:0] winner(input logic [127:0] req, input bit f);
        int best = -1;
        for (int n = 0; n < 128; n++)
            if (req[n] && br[n] == f && (best < 0 || bp[n] < bp[best])) best = n;
        return (best < 0) ? 32'h7F : 32'(best);
    endfunction

    task automatic settle2();
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < 128; n++) begin bp[n] = 0; br[n] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        for (int b = 0; b < 4; b++) begin rd(badr(b, 0), rv); chk("R10 mask reset", rv, 32'hFFFF_FFFF); end
        rd(1, rv); chk("R10 normal status reset", rv, 32'h7F);
        rd(2, rv); chk("R10 fast status reset", rv, 32'h7F);
        chk("R10 irq low", 32'(irq_o), 0);
        chk("R10 fiq low", 32'(fiq_o), 0);
        for (int n = 0; n < 128; n += 9) begin rd(256 + n, rv); chk("R10 level reset", rv, 0); end

        // R5 level register sweep with junk in unused bits
        for (int n = 0; n < 128; n++) set_level(n, (n * 37 + 11) % 128, (n % 3) == 0);
        for (int n = 0; n < 128; n++) begin
            rd(256 + n, rv);
            chk("R5 level readback", rv, (32'(bp[n]) << 2) | 32'(br[n]));
        end

        // R1 R3 R7 single-source sweep by software request
        for (int n = 0; n < 128; n++) begin
            wr(badr(n >> 5, 4), 32'h1 << (n & 31));
            wr(badr(n >> 5, 2), 32'h1 << (n & 31));
            @(negedge clk);
            rd(br[n] ? 2 : 1, rv); chk("R1 selected number", rv, 32'(n));
            rd(br[n] ? 1 : 2, rv); chk("R7 other line none", rv, 32'h7F);
            chk("R7 line level", {30'b0, fiq_o, irq_o}, br[n] ? 32'h2 : 32'h1);
            wr(badr(n >> 5, 1), 32'h1 << (n & 31));
            wr(badr(n >> 5, 5), 32'h1 << (n & 31));
            wr(0, 32'h3);
        end
        settle2();
        chk("R3 cleared requests idle", {30'b0, fiq_o, irq_o}, 0);

        // R4 raw pending ignores mask; R6 masked sources stay out
        for (int n = 0; n < 128; n++) src_in[n] = ((n * 7) % 11) < 4;
        wr(badr(2, 4), 32'h20);
        settle2();
        for (int b = 0; b < 4; b++) begin
            rd(badr(b, 3), rv);
            chk("R4 raw pending", rv, src_in[b*32 +: 32] | ((b == 2) ? 32'h20 : 32'h0));
        end
        chk("R6 all masked no line", {30'b0, fiq_o, irq_o}, 0);
        wr(badr(2, 5), 32'h20);
        rd(badr(2, 3), rv); chk("R3 software clear", rv, src_in[64 +: 32]);

        // R2 set/clear touch only ones
        wr(badr(1, 2), 32'h0000_0F0F);
        rd(badr(1, 0), rv); chk("R2 mask clear", rv, 32'hFFFF_F0F0);
        wr(badr(1, 1), 32'h0000_0100);
        rd(badr(1, 0), rv); chk("R2 mask set", rv, 32'hFFFF_F1F0);
        rd(badr(0, 0), rv); chk("R2 other bank kept", rv, 32'hFFFF_FFFF);

        // R6 whole-array arbitration
        src_in = '1;
        for (int b = 0; b < 4; b++) wr(badr(b, 2), 32'hFFFF_FFFF);
        wr(0, 32'h3);
        settle2();
        rd(1, rv); chk("R6 normal winner all", rv, winner('1, 0));
        rd(2, rv); chk("R6 fast winner all", rv, winner('1, 1));

        // R8 frozen while sources change
        src_in = '0;
        for (int n = 0; n < 128; n++) src_in[n] = (n % 5) == 2;
        repeat (3) @(negedge clk);
        rd(1, rv); chk("R8 normal frozen", rv, winner('1, 0));
        chk("R8 irq held", 32'(irq_o), 1);

        // R9 gap and re-pick on the normal line only
        wr(0, 32'h1);
        chk("R9 irq drops", 32'(irq_o), 0);
        rd(1, rv); chk("R9 status none in gap", rv, 32'h7F);
        rd(2, rv); chk("R9 fast unaffected", rv, winner('1, 1));
        @(negedge clk);
        chk("R9 irq still low", 32'(irq_o), 0);
        @(negedge clk);
        chk("R9 irq back", 32'(irq_o), 1);
        rd(1, rv); chk("R9 normal repick", rv, winner(src_in, 0));

        // R6 ties and masked winner
        for (int n = 0; n < 128; n++) set_level(n, 9, 0);
        src_in = '1;
        wr(0, 32'h3);
        settle2();
        rd(1, rv); chk("R6 tie lowest number", rv, 0);
        rd(2, rv); chk("R6 fast none", rv, 32'h7F);
        src_in = ~128'h3FF;
        wr(0, 32'h1);
        settle2();
        rd(1, rv); chk("R6 tie after removal", rv, 10);
        wr(badr(0, 1), 32'h400);
        wr(0, 32'h1);
        settle2();
        rd(1, rv); chk("R6 masked winner skipped", rv, 11);
        set_level(120, 3, 1);
        set_level(100, 3, 1);
        wr(0, 32'h2);
        settle2();
        rd(2, rv); chk("R6 fast tie", rv, 100);
        set_level(127, 2, 1);
        wr(0, 32'h2);
        settle2();
        rd(2, rv); chk("R6 fast source 127", rv, 127);
        chk("R7 fiq high", 32'(fiq_o), 1);

        // R10 reset during operation
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin rd(badr(b, 0), rv); chk("R10 mask after reset", rv, 32'hFFFF_FFFF); end
        rd(1, rv); chk("R10 status after reset", rv, 32'h7F);
        rd(256 + 100, rv); chk("R10 level after reset", rv, 0);
        chk("R10 lines after reset", {30'b0, fiq_o, irq_o}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule